// File: doc/BRIEF.md
# Pipelined Arithmetic AES Byte Substitution

This unit replaces one byte of an AES state with its substitution value by computing it rather than looking it up. It computes the multiplicative inverse in GF(2^8) and combines it with the affine map. The same arithmetic serves both directions. In forward (encrypt) mode the byte is inverted and then passed through the affine map. In reverse (decrypt) mode the byte first goes through the inverse affine map and is then inverted.

Inversion uses Fermat's identity, a^-1 = a^254. The exponent is built from seven linear squarings and six general multipliers arranged as a balanced product tree. That tree is cut by three registers, so a result leaves exactly three clocks after its byte enters. A valid flag and the direction bit move through the stages with the data. A round datapath places sixteen copies side by side, and each copy can take a new byte, in either direction, on every clock.

Top module: `aes_sbox_pipe`

## Requirements
- R1: With in_dec = 0, out_byte equals the affine map of the field inverse of the input. The field is GF(2^8) with polynomial x^8+x^4+x^3+x+1. The affine map is a ^ rotl(a,1) ^ rotl(a,2) ^ rotl(a,3) ^ rotl(a,4) ^ 0x63, where rotl rotates toward the MSB. Examples: 0x53 gives 0xED and 0x01 gives 0x7C.
- R2: With in_dec = 1, out_byte equals the field inverse of rotl(a,1) ^ rotl(a,3) ^ rotl(a,6) ^ 0x05. Examples: 0xED gives 0x53 and 0x00 gives 0x52.
- R3: The inverse of 0x00 is taken as 0x00. So forward 0x00 gives 0x63, and reverse 0x63 gives 0x00.
- R4: out_valid three cycles after an edge equals in_valid sampled at that edge. The result for a byte taken at edge n is on out_byte after edge n+3.
- R5: out_dec returns the direction bit of the byte whose result is on out_byte. The direction may differ on every cycle without affecting neighbouring bytes.
- R6: A new byte is accepted on every clock, giving one result per cycle with no stalls.
- R7: An active-low asynchronous reset (rst_n) drives out_valid, out_dec and out_byte to 0.
- R8: While out_valid is 0, out_byte keeps its last value. A cycle with in_valid = 0 produces no result, whatever in_byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte is valid this cycle |
| in_dec | input | 1 | 1 = reverse substitution, 0 = forward |
| in_byte | input | 8 | Byte to substitute |
| out_valid | output | 1 | Result valid |
| out_dec | output | 1 | Direction of the current result |
| out_byte | output | 8 | Substituted byte |

## Verification
A short table of known forward and reverse substitution pairs is sent one byte at a time. This pins down the affine constants, the rotation direction and the zero convention independently of any model. All 256 bytes are then streamed back to back, with the direction toggling on every cycle. Each result is compared against tables that the bench builds by brute-force inverse search. This separates a correct exponent chain from a wrong partial product, and it exposes a direction bit that slips a stage relative to its data. Finally, sparse valid patterns with junk bytes in the gaps, and a reset in mid-stream, show that bubbles leave out_byte unchanged and that reset clears the outputs.

// File: rtl/aes_sbox_pipe.sv
module aes_sbox_pipe #(
  parameter logic [7:0] RED_POLY = 8'h1B,
  parameter logic [7:0] FWD_C    = 8'h63,
  parameter logic [7:0] INV_C    = 8'h05
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_dec,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic       out_dec,
  output logic [7:0] out_byte
);

  localparam int N = 8;

  function automatic logic [N-1:0] gmul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] acc;
    logic [N-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < N; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[N-2:0], 1'b0} ^ (sh[N-1] ? RED_POLY : '0);
    end
    return acc;
  endfunction

  function automatic logic [N-1:0] fwd_aff(input logic [N-1:0] a);
    return a ^ {a[6:0], a[7]} ^ {a[5:0], a[7:6]} ^ {a[4:0], a[7:5]} ^ {a[3:0], a[7:4]} ^ FWD_C;
  endfunction

  function automatic logic [N-1:0] inv_aff(input logic [N-1:0] a);
    return {a[6:0], a[7]} ^ {a[4:0], a[7:5]} ^ {a[1:0], a[7:2]} ^ INV_C;
  endfunction

  // stage 0: direction pre-map and squaring ladder
  logic [N-1:0] pre;
  logic [N-1:0] sq [1:7];

  assign pre = in_dec ? inv_aff(in_byte) : in_byte;

  generate
    for (genvar k = 1; k <= 7; k++) begin : g_sq
      if (k == 1) begin : g_first
        assign sq[k] = gmul(pre, pre);
      end else begin : g_next
        assign sq[k] = gmul(sq[k-1], sq[k-1]);
      end
    end
  endgenerate

  // pipeline registers
  logic         s1_v, s1_d, s2_v, s2_d;
  logic [N-1:0] s1_p6, s1_p24, s1_p96, s1_p128;
  logic [N-1:0] s2_p30, s2_p224;
  logic [N-1:0] inv;

  assign inv = gmul(s2_p30, s2_p224);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_d <= 1'b0;
      s1_p6 <= '0; s1_p24 <= '0; s1_p96 <= '0; s1_p128 <= '0;
      s2_v <= 1'b0; s2_d <= 1'b0;
      s2_p30 <= '0; s2_p224 <= '0;
      out_valid <= 1'b0; out_dec <= 1'b0; out_byte <= '0;
    end else begin
      s1_v      <= in_valid;
      s2_v      <= s1_v;
      out_valid <= s2_v;
      if (in_valid) begin
        s1_d    <= in_dec;
        s1_p6   <= gmul(sq[1], sq[2]);
        s1_p24  <= gmul(sq[3], sq[4]);
        s1_p96  <= gmul(sq[5], sq[6]);
        s1_p128 <= sq[7];
      end
      if (s1_v) begin
        s2_d    <= s1_d;
        s2_p30  <= gmul(s1_p6, s1_p24);
        s2_p224 <= gmul(s1_p96, s1_p128);
      end
      if (s2_v) begin
        out_dec  <= s2_d;
        out_byte <= s2_d ? inv : fwd_aff(inv);
      end
    end
  end

endmodule

// File: rtl/aes_sbox_pipe_chk.sv
module aes_sbox_pipe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_dec,
  input logic [7:0] in_byte,
  input logic       out_valid,
  input logic       out_dec,
  input logic [7:0] out_byte
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R4
  latency_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R5
  mode_travel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid) |-> (out_dec == $past(in_dec, 3)));

  // R3
  zero_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && !out_dec && $past(in_byte, 3) == 8'h00) |-> (out_byte == 8'h63));

  // R3
  zero_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && out_valid && out_dec && $past(in_byte, 3) == 8'h63) |-> (out_byte == 8'h00));

  // R7
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd0) |-> (!out_valid && !out_dec && out_byte == 8'h00));

  // R8
  bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !out_valid) |-> $stable(out_byte));

endmodule

bind aes_sbox_pipe aes_sbox_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec), .in_byte(in_byte),
  .out_valid(out_valid), .out_dec(out_dec), .out_byte(out_byte)
);

// File: tb/aes_sbox_pipe_tb.sv
module aes_sbox_pipe_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_dec;
  logic [7:0] in_byte;
  logic       out_valid, out_dec;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aes_sbox_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec), .in_byte(in_byte),
    .out_valid(out_valid), .out_dec(out_dec), .out_byte(out_byte)
  );

  // {dec, input, expected}
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h63}, {1'b0, 8'h01, 8'h7C}, {1'b0, 8'h02, 8'h77}, {1'b0, 8'h03, 8'h7B},
    {1'b0, 8'h10, 8'hCA}, {1'b0, 8'h11, 8'h82}, {1'b0, 8'h53, 8'hED}, {1'b0, 8'h80, 8'hCD},
    {1'b0, 8'hFF, 8'h16}, {1'b0, 8'hF0, 8'h8C},
    {1'b1, 8'h63, 8'h00}, {1'b1, 8'h7C, 8'h01}, {1'b1, 8'hED, 8'h53}, {1'b1, 8'h16, 8'hFF},
    {1'b1, 8'h00, 8'h52}, {1'b1, 8'h01, 8'h09}, {1'b1, 8'hFF, 8'h7D}
  };

  logic [7:0] sb [256];
  logic [7:0] isb [256];

  function automatic logic [7:0] mref(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (a[i]) p = p ^ (16'(b) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
    return p[7:0];
  endfunction

  task automatic build_model();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] iv, s;
      iv = 8'h00;
      for (int y = 1; y < 256; y++) if (mref(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = iv[i] ^ iv[(i+4)%8] ^ iv[(i+5)%8] ^ iv[(i+6)%8] ^ iv[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[x] = s;
    end
    for (int x = 0; x < 256; x++) isb[sb[x]] = 8'(x);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  logic       hv [3];
  logic       hd [3];
  logic [7:0] hb [3];
  logic [7:0] last_out;

  task automatic step(input logic v, input logic d, input logic [7:0] b, input string tag);
    logic [7:0] e;
    @(negedge clk);
    if (hv[2]) begin
      e = hd[2] ? isb[hb[2]] : sb[hb[2]];
      check("R4", 8'(out_valid), 8'd1);
      check("R5", 8'(out_dec), 8'(hd[2]));
      check(hd[2] ? {tag, "/R2"} : {tag, "/R1"}, out_byte, e);
      last_out = e;
    end else begin
      check("R4", 8'(out_valid), 8'd0);
      check("R8", out_byte, last_out);
    end
    for (int k = 2; k > 0; k--) begin
      hv[k] = hv[k-1]; hd[k] = hd[k-1]; hb[k] = hb[k-1];
    end
    hv[0] = v; hd[0] = d; hb[0] = b;
    in_valid = v; in_dec = d; in_byte = b;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_dec = 1'b0; in_byte = 8'h00;
    build_model();
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7", 8'(out_valid), 8'd0);
    check("R7", 8'(out_dec), 8'd0);
    check("R7", out_byte, 8'h00);
    rst_n = 1'b1;

    // directed table, one byte at a time (R1, R2, R3, R4)
    for (int i = 0; i < NV; i++) begin
      logic d;
      logic [7:0] x, e;
      string t;
      {d, x, e} = VEC[i];
      t = ((!d && x == 8'h00) || (d && x == 8'h63)) ? "R3" : (d ? "R2" : "R1");
      @(negedge clk);
      in_valid = 1'b1; in_dec = d; in_byte = x;
      @(negedge clk);
      in_valid = 1'b0; in_byte = 8'hA5;
      @(negedge clk);
      check("R4", 8'(out_valid), 8'd0);
      @(negedge clk);
      check("R4", 8'(out_valid), 8'd1);
      check("R5", 8'(out_dec), 8'(d));
      check(t, out_byte, e);
      last_out = e;
    end

    for (int k = 0; k < 3; k++) begin
      hv[k] = 1'b0; hd[k] = 1'b0; hb[k] = 8'h00;
    end

    // R6: full sweep, back to back, direction toggling each cycle
    for (int i = 0; i < 512; i++) step(1'b1, i[0], i[8:1], "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 8'h3C, "R8");

    // R8: bubbles with junk bytes in the gaps
    for (int i = 0; i < 16; i++) begin
      logic v;
      v = (i % 3 == 0) || (i == 7);
      step(v, i[1], v ? 8'(i * 37) : 8'hE7, "R8");
    end
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'h5A, "R8");

    // R7: reset while data is in flight
    step(1'b1, 1'b1, 8'h42, "R7");
    step(1'b1, 1'b0, 8'h99, "R7");
    step(1'b1, 1'b1, 8'hC3, "R7");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7", 8'(out_valid), 8'd0);
    check("R7", 8'(out_dec), 8'd0);
    check("R7", out_byte, 8'h00);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", 8'(out_valid), 8'd0);
    check("R7", out_byte, 8'h00);

    finish_run();
  end

endmodule